// File: doc/BRIEF.md
# Processor Halt Power-State Controller

This block manages the low-power halt states of a processor package that runs two logical threads. It watches a halt indication from each thread. Only when every thread is halted does the package leave the running state, and it then enters one of two halt states. A configuration enable picks between a plain halt and a deeper halt. The deeper halt drops the core clock ratio and then the supply voltage ID. Five break events (system management interrupt, bus init, init, non-maskable interrupt, maskable interrupt) wake the package. A stop-clock request parks a halted package in a stop-grant state. Snoop requests made while halted are acknowledged.

Every ratio or voltage step is followed by a settle window of a parameterised number of cycles before the next step may start. A busy flag is high during any such sequence. A break that arrives while the package is entering the deeper halt unwinds the steps already taken, in reverse order, and skips none of them. The nominal and low operating points come from configuration inputs and are captured at reset. The external bus ratio output never changes.

Top module: `halt_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after it rises, the block captures the four operating-point inputs, and later changes to them have no effect. During reset `pwr_state` is 0 (running), `core_ratio` and `core_vid` show the captured nominal values, and `busy` and `snoop_ack` are 0.
- R2: If only some of the `thread_halt` bits are set, `pwr_state` stays 0. If a break event is present in the same cycle that all threads are halted, `pwr_state` also stays 0.
- R3: When all threads are halted with `deep_en` low, `pwr_state` becomes 1 (plain halt) on the next edge, and ratio and voltage stay nominal.
- R4: When all threads are halted with `deep_en` high, the block first spends SETTLE_CYC cycles in state 4 with the low ratio and the nominal voltage. It then spends SETTLE_CYC cycles in state 5 with the low ratio and the low voltage, and then enters state 2 (deep halt). `busy` is 1 exactly in states 4 to 7.
- R5: In state 1, any one of the five break inputs returns `pwr_state` to 0 on the next edge.
- R6: In state 2, a break moves the block to state 6, where the voltage is nominal and the ratio is still low, for SETTLE_CYC cycles. It then moves to state 7, where both values are nominal, for SETTLE_CYC cycles, and then to state 0.
- R7: A break in state 4 leads to state 7 with the nominal ratio restored. A break in state 5 leads to state 6 with the nominal voltage restored. Each then completes the exit path of R6.
- R8: `stop_clk_req` in state 1 or 2 moves the block to state 3 (stop grant), and the ratio and voltage are held. Break inputs have no effect in state 3. When the request drops, the block returns to the halt state it left.
- R9: `snoop_req` sampled at an edge while in state 1 or 2 gives `snoop_ack` high after that same edge. In any other state it gives no acknowledge.
- R10: `bus_ratio` equals the BUS_RATIO parameter in every state.
- R11: The low voltage ID is never applied while the core ratio is nominal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| thread_halt | input | N_THREADS | Per-thread halt indication |
| brk_smi | input | 1 | Break: system management interrupt |
| brk_binit | input | 1 | Break: bus init |
| brk_init | input | 1 | Break: init |
| brk_nmi | input | 1 | Break: non-maskable interrupt |
| brk_intr | input | 1 | Break: maskable interrupt |
| stop_clk_req | input | 1 | Stop-clock request |
| snoop_req | input | 1 | Snoop request |
| deep_en | input | 1 | Selects the deeper halt state |
| cfg_ratio_nom | input | RATIO_W | Nominal core ratio, captured at reset |
| cfg_ratio_lo | input | RATIO_W | Low core ratio, captured at reset |
| cfg_vid_nom | input | VID_W | Nominal voltage ID, captured at reset |
| cfg_vid_lo | input | VID_W | Low voltage ID, captured at reset |
| pwr_state | output | 3 | Power state code (0 run, 1 halt, 2 deep, 3 stop grant, 4..7 transitions) |
| core_ratio | output | RATIO_W | Core clock ratio select |
| core_vid | output | VID_W | Voltage ID code |
| bus_ratio | output | BUS_W | External bus ratio, constant |
| busy | output | 1 | Ratio/voltage sequence in progress |
| snoop_ack | output | 1 | Snoop acknowledge |

## Verification
The assertions check the following on every cycle:
- the voltage is never low while the ratio is nominal;
- the ratio is already low when the voltage drops, and still low when the voltage is restored;
- the settle counter counts down one step per cycle;
- a partial halt never leaves the running state;
- a break in plain halt wakes the package;
- stop grant returns to a halt state;
- a snoop in either halt state is acknowledged.

The bench scenarios are needed for the rest. They show that reset captures the configuration and that later input changes are ignored. They show the exact length of each settle window, and that an aborted entry resumes the exit at the right step. They also show that the block returns to the particular halt state it left after a stop grant, that breaks are ignored during stop grant, and that the bus ratio stays constant.

// File: rtl/halt_pwr_pkg.sv
package halt_pwr_pkg;

  typedef enum logic [2:0] {
    PS_RUN       = 3'd0,
    PS_HALT      = 3'd1,
    PS_DEEP      = 3'd2,
    PS_STOPGNT   = 3'd3,
    PS_IN_RATIO  = 3'd4,
    PS_IN_VID    = 3'd5,
    PS_OUT_VID   = 3'd6,
    PS_OUT_RATIO = 3'd7
  } pstate_e;

endpackage

// File: rtl/halt_wake_detect.sv
module halt_wake_detect #(
  parameter int N_THREADS = 2
) (
  input  logic [N_THREADS-1:0] thread_halt,
  input  logic                 brk_smi,
  input  logic                 brk_binit,
  input  logic                 brk_init,
  input  logic                 brk_nmi,
  input  logic                 brk_intr,
  output logic                 all_halted,
  output logic                 wake
);

  localparam int N_BRK = 5;

  logic [N_BRK-1:0] brk_vec;

  assign brk_vec    = {brk_intr, brk_nmi, brk_init, brk_binit, brk_smi};
  assign wake       = |brk_vec;
  assign all_halted = &thread_halt;

endmodule

// File: rtl/halt_settle_timer.sv
module halt_settle_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);

  generate
    if (SETTLE_CYC > 1) begin : g_cnt
      localparam int CW = $clog2(SETTLE_CYC);
      localparam logic [CW-1:0] LOADV = CW'(SETTLE_CYC - 1);
      localparam logic [CW-1:0] ONE   = CW'(1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (start) begin
          cnt_d = LOADV;
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - ONE;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign done = (cnt_q == '0);

      // R4: each settle window shrinks by one per cycle, never skips
      assert_settle_countdown_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE)
      );
    end else begin : g_none
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ start;
      assign done = 1'b1 | unused_in;
    end
  endgenerate

endmodule

// File: rtl/halt_oppoint_regs.sv
module halt_oppoint_regs #(
  parameter int RATIO_W = 6,
  parameter int VID_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] cfg_ratio_nom,
  input  logic [RATIO_W-1:0] cfg_ratio_lo,
  input  logic [VID_W-1:0]   cfg_vid_nom,
  input  logic [VID_W-1:0]   cfg_vid_lo,
  input  logic               ratio_lo_sel,
  input  logic               vid_lo_sel,
  output logic [RATIO_W-1:0] core_ratio,
  output logic [VID_W-1:0]   core_vid
);

  logic               load_q;
  logic [RATIO_W-1:0] ratio_nom_q;
  logic [RATIO_W-1:0] ratio_lo_q;
  logic [VID_W-1:0]   vid_nom_q;
  logic [VID_W-1:0]   vid_lo_q;

  // capture window: throughout reset and the first edge after release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b1;
    end else begin
      load_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load_q) begin
      ratio_nom_q <= cfg_ratio_nom;
      ratio_lo_q  <= cfg_ratio_lo;
      vid_nom_q   <= cfg_vid_nom;
      vid_lo_q    <= cfg_vid_lo;
    end
  end

  assign core_ratio = ratio_lo_sel ? ratio_lo_q : ratio_nom_q;
  assign core_vid   = vid_lo_sel   ? vid_lo_q   : vid_nom_q;

endmodule

// File: rtl/halt_pwr_ctrl.sv
module halt_pwr_ctrl
  import halt_pwr_pkg::*;
#(
  parameter int N_THREADS  = 2,
  parameter int RATIO_W    = 6,
  parameter int VID_W      = 6,
  parameter int BUS_W      = 4,
  parameter int BUS_RATIO  = 5,
  parameter int SETTLE_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_THREADS-1:0] thread_halt,
  input  logic                 brk_smi,
  input  logic                 brk_binit,
  input  logic                 brk_init,
  input  logic                 brk_nmi,
  input  logic                 brk_intr,
  input  logic                 stop_clk_req,
  input  logic                 snoop_req,
  input  logic                 deep_en,
  input  logic [RATIO_W-1:0]   cfg_ratio_nom,
  input  logic [RATIO_W-1:0]   cfg_ratio_lo,
  input  logic [VID_W-1:0]     cfg_vid_nom,
  input  logic [VID_W-1:0]     cfg_vid_lo,
  output logic [2:0]           pwr_state,
  output logic [RATIO_W-1:0]   core_ratio,
  output logic [VID_W-1:0]     core_vid,
  output logic [BUS_W-1:0]     bus_ratio,
  output logic                 busy,
  output logic                 snoop_ack
);

  localparam logic [BUS_W-1:0] BUS_CONST = BUS_W'(BUS_RATIO);

  pstate_e st_q, st_d;
  logic    rlo_q, rlo_d;
  logic    vlo_q, vlo_d;
  logic    org_deep_q, org_deep_d;
  logic    ack_q, ack_d;
  logic    tmr_start, tmr_done;
  logic    all_halted, wake;
  logic    in_halt;

  halt_wake_detect #(.N_THREADS(N_THREADS)) u_wake (
    .thread_halt (thread_halt),
    .brk_smi     (brk_smi),
    .brk_binit   (brk_binit),
    .brk_init    (brk_init),
    .brk_nmi     (brk_nmi),
    .brk_intr    (brk_intr),
    .all_halted  (all_halted),
    .wake        (wake)
  );

  halt_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .done  (tmr_done)
  );

  halt_oppoint_regs #(.RATIO_W(RATIO_W), .VID_W(VID_W)) u_opp (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_ratio_nom (cfg_ratio_nom),
    .cfg_ratio_lo  (cfg_ratio_lo),
    .cfg_vid_nom   (cfg_vid_nom),
    .cfg_vid_lo    (cfg_vid_lo),
    .ratio_lo_sel  (rlo_q),
    .vid_lo_sel    (vlo_q),
    .core_ratio    (core_ratio),
    .core_vid      (core_vid)
  );

  assign in_halt = (st_q == PS_HALT) || (st_q == PS_DEEP);

  // next-state logic
  always_comb begin
    st_d       = st_q;
    rlo_d      = rlo_q;
    vlo_d      = vlo_q;
    org_deep_d = org_deep_q;
    tmr_start  = 1'b0;
    ack_d      = snoop_req && in_halt;
    case (st_q)
      PS_RUN: begin
        if (all_halted && !wake) begin
          if (deep_en) begin
            st_d      = PS_IN_RATIO;
            rlo_d     = 1'b1;
            tmr_start = 1'b1;
          end else begin
            st_d = PS_HALT;
          end
        end
      end
      PS_HALT: begin
        if (wake) begin
          st_d = PS_RUN;
        end else if (stop_clk_req) begin
          st_d       = PS_STOPGNT;
          org_deep_d = 1'b0;
        end
      end
      PS_DEEP: begin
        if (wake) begin
          st_d      = PS_OUT_VID;
          vlo_d     = 1'b0;
          tmr_start = 1'b1;
        end else if (stop_clk_req) begin
          st_d       = PS_STOPGNT;
          org_deep_d = 1'b1;
        end
      end
      PS_STOPGNT: begin
        if (!stop_clk_req) begin
          st_d = org_deep_q ? PS_DEEP : PS_HALT;
        end
      end
      PS_IN_RATIO: begin
        if (wake) begin
          st_d      = PS_OUT_RATIO;
          rlo_d     = 1'b0;
          tmr_start = 1'b1;
        end else if (tmr_done) begin
          st_d      = PS_IN_VID;
          vlo_d     = 1'b1;
          tmr_start = 1'b1;
        end
      end
      PS_IN_VID: begin
        if (wake) begin
          st_d      = PS_OUT_VID;
          vlo_d     = 1'b0;
          tmr_start = 1'b1;
        end else if (tmr_done) begin
          st_d = PS_DEEP;
        end
      end
      PS_OUT_VID: begin
        if (tmr_done) begin
          st_d      = PS_OUT_RATIO;
          rlo_d     = 1'b0;
          tmr_start = 1'b1;
        end
      end
      PS_OUT_RATIO: begin
        if (tmr_done) begin
          st_d = PS_RUN;
        end
      end
      default: begin
        st_d  = PS_RUN;
        rlo_d = 1'b0;
        vlo_d = 1'b0;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= PS_RUN;
      rlo_q      <= 1'b0;
      vlo_q      <= 1'b0;
      org_deep_q <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      rlo_q      <= rlo_d;
      vlo_q      <= vlo_d;
      org_deep_q <= org_deep_d;
      ack_q      <= ack_d;
    end
  end

  assign pwr_state = st_q;
  assign busy      = st_q[2];
  assign snoop_ack = ack_q;
  assign bus_ratio = BUS_CONST;

  // R11: low voltage only on top of low ratio
  assert_vid_needs_low_ratio_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    vlo_q |-> rlo_q
  );

  // R4: ratio was already low when the voltage dropped
  assert_ratio_before_vid_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(vlo_q) |-> $past(rlo_q)
  );

  // R6: the voltage is restored while the ratio is still low
  assert_vid_before_ratio_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    $fell(vlo_q) |-> rlo_q
  );

  // R2: a partial halt never leaves the running state
  assert_partial_halt_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (st_q == PS_RUN && !all_halted) |=> (st_q == PS_RUN)
  );

  // R5: a break in plain halt wakes the package
  assert_halt_wake_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (st_q == PS_HALT && wake) |=> (st_q == PS_RUN)
  );

  // R8: releasing stop-clock returns to a halt state
  assert_stopgnt_return_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (st_q == PS_STOPGNT && !stop_clk_req) |=> (st_q == PS_HALT || st_q == PS_DEEP)
  );

  // R9: a snoop in either halt state is acknowledged
  assert_snoop_ack_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    (snoop_req && in_halt) |=> snoop_ack
  );

endmodule

// File: tb/test_halt_pwr_ctrl.sv
`timescale 1ns/1ps
module test_halt_pwr_ctrl;

  localparam int SETTLE = 4;
  localparam int BUSR   = 5;
  localparam logic [5:0] R_NOM = 6'd20;
  localparam logic [5:0] R_LO  = 6'd12;
  localparam logic [5:0] V_NOM = 6'd40;
  localparam logic [5:0] V_LO  = 6'd25;

  logic       clk;
  logic       rst_n;
  logic [1:0] thread_halt;
  logic [4:0] brk;
  logic       stop_clk_req, snoop_req, deep_en;
  logic [5:0] cfg_ratio_nom, cfg_ratio_lo, cfg_vid_nom, cfg_vid_lo;
  logic [2:0] pwr_state;
  logic [5:0] core_ratio, core_vid;
  logic [3:0] bus_ratio;
  logic       busy, snoop_ack;

  halt_pwr_ctrl #(
    .N_THREADS(2), .RATIO_W(6), .VID_W(6), .BUS_W(4),
    .BUS_RATIO(BUSR), .SETTLE_CYC(SETTLE)
  ) i_halt_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .thread_halt(thread_halt),
    .brk_smi(brk[0]), .brk_binit(brk[1]), .brk_init(brk[2]),
    .brk_nmi(brk[3]), .brk_intr(brk[4]),
    .stop_clk_req(stop_clk_req), .snoop_req(snoop_req), .deep_en(deep_en),
    .cfg_ratio_nom(cfg_ratio_nom), .cfg_ratio_lo(cfg_ratio_lo),
    .cfg_vid_nom(cfg_vid_nom), .cfg_vid_lo(cfg_vid_lo),
    .pwr_state(pwr_state), .core_ratio(core_ratio), .core_vid(core_vid),
    .bus_ratio(bus_ratio), .busy(busy), .snoop_ack(snoop_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [2:0] st;
    logic [5:0] ratio;
    logic [5:0] vid;
    logic       ack;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic compare_now(input exp_t e);
    chk(pwr_state == e.st, e.tag, "pwr_state", pwr_state, e.st);
    chk(core_ratio == e.ratio, e.tag, "core_ratio", core_ratio, e.ratio);
    chk(core_vid == e.vid, e.tag, "core_vid", core_vid, e.vid);
    // R4: busy exactly in codes 4..7
    chk(busy == e.st[2], e.tag, "busy", busy, e.st[2]);
    chk(snoop_ack == e.ack, e.tag, "snoop_ack", snoop_ack, e.ack);
    // R10: constant bus ratio
    chk(bus_ratio == 4'(BUSR), "R10", "bus_ratio", bus_ratio, BUSR);
  endtask

  // monitor: pops one expectation per edge, samples 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      compare_now(q.pop_front());
    end
  end

  // driver: expectation for the coming edge, then wait for the next negedge
  task automatic tick(input logic [2:0] st, input bit rlo, input bit vlo,
                      input bit ack, input string tag);
    exp_t e;
    e.st    = st;
    e.ratio = rlo ? R_LO : R_NOM;
    e.vid   = vlo ? V_LO : V_NOM;
    e.ack   = ack;
    e.tag   = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic go_halt();
    thread_halt = 2'b11;
    deep_en     = 1'b0;
    tick(3'd1, 0, 0, 0, "R3");
  endtask

  // R4 and R11: ratio first, voltage second, each for SETTLE cycles
  task automatic go_deep();
    thread_halt = 2'b11;
    deep_en     = 1'b1;
    repeat (SETTLE) tick(3'd4, 1, 0, 0, "R4");
    repeat (SETTLE) tick(3'd5, 1, 1, 0, "R4");
    tick(3'd2, 1, 1, 0, "R4");
  endtask

  // R6: voltage back first, ratio back second
  task automatic exit_deep(input int which);
    brk[which]  = 1'b1;
    tick(3'd6, 1, 0, 0, "R6");
    brk         = '0;
    thread_halt = 2'b00;
    repeat (SETTLE - 1) tick(3'd6, 1, 0, 0, "R6");
    repeat (SETTLE) tick(3'd7, 0, 0, 0, "R6");
    tick(3'd0, 0, 0, 0, "R6");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    thread_halt = 2'b00; brk = '0;
    stop_clk_req = 1'b0; snoop_req = 1'b0; deep_en = 1'b0;
    cfg_ratio_nom = R_NOM; cfg_ratio_lo = R_LO;
    cfg_vid_nom   = V_NOM; cfg_vid_lo   = V_LO;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(pwr_state == 3'd0, "R1", "pwr_state", pwr_state, 0);
    chk(core_ratio == R_NOM, "R1", "core_ratio", core_ratio, R_NOM);
    chk(core_vid == V_NOM, "R1", "core_vid", core_vid, V_NOM);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(snoop_ack == 1'b0, "R1", "snoop_ack", snoop_ack, 0);
    rst_n = 1'b1;
    tick(3'd0, 0, 0, 0, "R1");
    // R1: later changes to the operating points are ignored
    cfg_ratio_nom = 6'd33; cfg_ratio_lo = 6'd7;
    cfg_vid_nom   = 6'd50; cfg_vid_lo   = 6'd3;
    tick(3'd0, 0, 0, 0, "R1");

    // R2: partial halt and halt with a coincident break
    thread_halt = 2'b01;
    repeat (3) tick(3'd0, 0, 0, 0, "R2");
    thread_halt = 2'b10;
    repeat (3) tick(3'd0, 0, 0, 0, "R2");
    thread_halt = 2'b11; brk[2] = 1'b1;
    tick(3'd0, 0, 0, 0, "R2");
    thread_halt = 2'b00; brk = '0;
    tick(3'd0, 0, 0, 0, "R2");

    // R9: no acknowledge while running
    snoop_req = 1'b1;
    tick(3'd0, 0, 0, 0, "R9");
    snoop_req = 1'b0;

    // R3 and R5: each break source wakes plain halt
    for (int i = 0; i < 5; i++) begin
      go_halt();
      brk[i] = 1'b1; thread_halt = 2'b00;
      tick(3'd0, 0, 0, 0, "R5");
      brk = '0;
    end

    // R9: acknowledge in plain halt
    go_halt();
    snoop_req = 1'b1;
    tick(3'd1, 0, 0, 1, "R9");
    snoop_req = 1'b0;
    tick(3'd1, 0, 0, 0, "R9");

    // R8: stop grant from plain halt, breaks ignored, back to plain halt
    stop_clk_req = 1'b1;
    tick(3'd3, 0, 0, 0, "R8");
    brk[3] = 1'b1;
    repeat (2) tick(3'd3, 0, 0, 0, "R8");
    brk = '0; stop_clk_req = 1'b0;
    tick(3'd1, 0, 0, 0, "R8");
    brk[4] = 1'b1; thread_halt = 2'b00;
    tick(3'd0, 0, 0, 0, "R5");
    brk = '0;

    // R4, R6, R9: deep halt entry, snoop, exit
    go_deep();
    snoop_req = 1'b1;
    tick(3'd2, 1, 1, 1, "R9");
    snoop_req = 1'b0;
    exit_deep(0);

    // R8: stop grant from deep halt keeps the low point, returns to deep
    go_deep();
    stop_clk_req = 1'b1;
    repeat (2) tick(3'd3, 1, 1, 0, "R8");
    stop_clk_req = 1'b0;
    tick(3'd2, 1, 1, 0, "R8");
    exit_deep(2);

    // R7: break during the ratio step
    thread_halt = 2'b11; deep_en = 1'b1;
    repeat (2) tick(3'd4, 1, 0, 0, "R7");
    brk[1] = 1'b1; thread_halt = 2'b00;
    tick(3'd7, 0, 0, 0, "R7");
    brk = '0;
    repeat (SETTLE - 1) tick(3'd7, 0, 0, 0, "R7");
    tick(3'd0, 0, 0, 0, "R7");

    // R7: break during the voltage step
    thread_halt = 2'b11;
    repeat (SETTLE) tick(3'd4, 1, 0, 0, "R7");
    tick(3'd5, 1, 1, 0, "R7");
    brk[4] = 1'b1; thread_halt = 2'b00;
    tick(3'd6, 1, 0, 0, "R7");
    brk = '0;
    repeat (SETTLE - 1) tick(3'd6, 1, 0, 0, "R7");
    repeat (SETTLE) tick(3'd7, 0, 0, 0, "R7");
    tick(3'd0, 0, 0, 0, "R7");

    repeat (2) @(negedge clk);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule